// File: doc/BRIEF.md
# Double-Buffered Transparent Pixel Store Writer

This block is the host-side write path into two on-chip pixel stores. Each store word is 16 bits wide and holds two 8-bit palette indices. One store is on display while the other is drawn into. A write always lands in the store that is not on display. Which store is on display comes from bit 5 of a control word that the block shares with the display side. Bit 6 of the same word turns on a transparency mode. In that mode a zero palette index never replaces what is already stored, so sprites drawn with index 0 as the clear colour keep the picture behind them.

Every write is a read-modify-write. In the cycle the host's write is accepted, the block reads the old word from the target store. In the next cycle it merges the new data and stores the result, and `host_ready` is low during that cycle. The merge applies transparency first. The host byte enables then mask the merged word, so a disabled byte lane is never changed. A registered read port with one cycle of latency lets the display side fetch from either store.

Top module: `fb_host_writer`

## Requirements
- R1: During reset `host_ready` is low and the stored copies of both control bits are cleared. The first write accepted after reset therefore goes to store 1 whatever value bit 5 has at that moment.
- R2: While control bit 5 is 1, host writes change store 0 only and leave store 1 untouched.
- R3: While control bit 5 is 0, host writes change store 1 only and leave store 0 untouched.
- R4: While control bit 6 is 0, a write stores data bits 7:0 when `host_be[0]` is 1 and data bits 15:8 when `host_be[1]` is 1. A lane whose enable is 0 keeps its old value.
- R5: While control bit 6 is 1, a write with data 16'h0000 leaves the addressed word unchanged, even with both byte enables set.
- R6: While control bit 6 is 1 and data bits 7:0 are zero, the stored low byte is kept and only the high byte may change.
- R7: While control bit 6 is 1 and data bits 15:8 are zero, the stored high byte is kept and only the low byte may change.
- R8: The byte enables mask the word after the transparency merge. In transparency mode a nonzero byte in a disabled lane is not written, and a zero byte in an enabled lane is not written.
- R9: A write is accepted on a clock edge where both `host_valid` and `host_ready` are 1. `host_ready` is then low for exactly one cycle and high again in the next.
- R10: `scan_data` shows the word at `scan_addr` in the store chosen by `scan_sel` one clock after they are presented. This holds for every address, the last one included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 16 | Shared control word; bit 5 selects the store on display, bit 6 turns on transparency |
| host_valid | input | 1 | Host write request |
| host_ready | output | 1 | Block can accept a write this cycle |
| host_addr | input | ADDR_W | Word address of the write |
| host_be | input | 2 | Byte enables, bit 0 for data bits 7:0 |
| host_wdata | input | 16 | Write data, two palette indices |
| scan_sel | input | 1 | Store to read on the display port |
| scan_addr | input | ADDR_W | Word address on the display port |
| scan_data | output | 16 | Word read, one cycle after the address |

## Verification
A wrong buffer-select copy shows as a word landing in the store on display. The other store's word then keeps its old value, and this can be read on the scan port two cycles after the write is accepted. A bad merge, or a captured request that is stale, shows as a wrong byte in the read-back word of that same write. A stuck sequencer shows at once on `host_ready`, which must drop for exactly one cycle after every acceptance. Each write is therefore read back right after it completes, so an error is tied to the write that caused it.

// File: rtl/fb_pkg.sv
// Shared definitions for the double-buffered pixel store writer.
// Assumes two byte lanes per word and a fixed position of the two
// control bits inside the shared control word.
package fb_pkg;
    localparam int CTRL_W         = 16;
    localparam int CTRL_DISP_BIT  = 5;
    localparam int CTRL_TRANS_BIT = 6;

    typedef enum logic {
        WR_IDLE  = 1'b0,
        WR_STORE = 1'b1
    } wr_state_t;
endpackage

// File: rtl/fb_ctrl_sync.sv
// Keeps registered copies of the display-select and transparency bits.
// Assumes the control word is stable for at least one cycle before a
// write that depends on it; reset clears both copies.
module fb_ctrl_sync
    import fb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic              disp_copy,
    output logic              trans_copy
);
    // Sample the two control bits every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_copy  <= 1'b0;
            trans_copy <= 1'b0;
        end else begin
            disp_copy  <= ctrl_word[CTRL_DISP_BIT];
            trans_copy <= ctrl_word[CTRL_TRANS_BIT];
        end
    end

    // R1: reset leaves both copies cleared on the following cycle.
    assert_copy_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!disp_copy && !trans_copy));
endmodule

// File: rtl/fb_merge.sv
// Combines a new word with the old stored word. Transparency drops zero
// lanes, then the byte enables drop disabled lanes. Purely combinational;
// assumes old_word is the current content of the target address.
module fb_merge #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] new_word,
    input  logic [LANES-1:0]  lane_en,
    input  logic              trans,
    output logic [DATA_W-1:0] merged,
    output logic              skip
);
    logic [LANES-1:0] lane_zero;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Zero-lane detect feeding the per-lane keep decision.
        always_comb lane_zero[g] = (new_word[g*LANE_W +: LANE_W] == '0);

        // Select old or new byte for this lane.
        always_comb begin
            if (!lane_en[g] || (trans && lane_zero[g]))
                merged[g*LANE_W +: LANE_W] = old_word[g*LANE_W +: LANE_W];
            else
                merged[g*LANE_W +: LANE_W] = new_word[g*LANE_W +: LANE_W];
        end
    end

    // A fully transparent word needs no store at all.
    always_comb skip = trans && (&lane_zero);
endmodule

// File: rtl/fb_bank.sv
// One pixel store: a write port, a read port for the read-modify-write
// path and a second read port for display fetch. Reads are registered.
// Contents are not reset.
module fb_bank #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] sc_addr,
    output logic [DATA_W-1:0] sc_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store the merged word.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    // Fetch the old word for the merge.
    always_ff @(posedge clk) begin
        if (rd_en)
            rd_data <= mem[rd_addr];
    end

    // Display-side fetch, every cycle.
    always_ff @(posedge clk) begin
        sc_data <= mem[sc_addr];
    end
endmodule

// File: rtl/fb_host_writer.sv
// Host write port into two pixel stores. A write is accepted in IDLE,
// which reads the old word from the store not on display. STORE writes
// the merged word back. Assumes one outstanding write at a time; the
// host holds its request until it sees ready.
module fb_host_writer
    import fb_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int DATA_W  = LANE_W * LANES,
    localparam int NUM_BUF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [LANES-1:0]  host_be,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              scan_sel,
    input  logic [ADDR_W-1:0] scan_addr,
    output logic [DATA_W-1:0] scan_data
);
    wr_state_t         state;
    logic              disp_copy, trans_copy;
    logic              accept;
    logic              tgt_bank;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [LANES-1:0]  be_q;
    logic              bank_q, trans_q;
    logic              scan_sel_q;
    logic [DATA_W-1:0] old_word, merged;
    logic              skip;
    logic [NUM_BUF-1:0] wr_en, rd_en;
    logic [DATA_W-1:0] rd_data [NUM_BUF];
    logic [DATA_W-1:0] sc_data [NUM_BUF];

    fb_ctrl_sync u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_word  (ctrl_word),
        .disp_copy  (disp_copy),
        .trans_copy (trans_copy)
    );

    // Handshake and target selection: write goes to the hidden store.
    always_comb begin
        host_ready = (state == WR_IDLE) && rst_n;
        accept     = host_valid && host_ready;
        tgt_bank   = ~disp_copy;
    end

    // Sequencer: IDLE reads the old word, STORE writes it back.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= WR_IDLE;
        else if (state == WR_IDLE && accept)
            state <= WR_STORE;
        else if (state == WR_STORE)
            state <= WR_IDLE;
    end

    // Capture the request and its control bits at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            data_q  <= '0;
            be_q    <= '0;
            bank_q  <= 1'b0;
            trans_q <= 1'b0;
        end else if (accept) begin
            addr_q  <= host_addr;
            data_q  <= host_wdata;
            be_q    <= host_be;
            bank_q  <= tgt_bank;
            trans_q <= trans_copy;
        end
    end

    // Remember which store the display port asked for.
    always_ff @(posedge clk) begin
        if (!rst_n)
            scan_sel_q <= 1'b0;
        else
            scan_sel_q <= scan_sel;
    end

    // Old word from the store that was read at acceptance.
    always_comb old_word = rd_data[bank_q];

    fb_merge #(.LANE_W(LANE_W), .LANES(LANES)) u_merge (
        .old_word (old_word),
        .new_word (data_q),
        .lane_en  (be_q),
        .trans    (trans_q),
        .merged   (merged),
        .skip     (skip)
    );

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_bank
        // Per-store read and write strobes.
        always_comb begin
            rd_en[b] = accept && (tgt_bank == b[0]);
            wr_en[b] = (state == WR_STORE) && !skip && (bank_q == b[0]);
        end

        fb_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
            .clk     (clk),
            .wr_en   (wr_en[b]),
            .wr_addr (addr_q),
            .wr_data (merged),
            .rd_en   (rd_en[b]),
            .rd_addr (host_addr),
            .rd_data (rd_data[b]),
            .sc_addr (scan_addr),
            .sc_data (sc_data[b])
        );
    end

    // Display-port output mux.
    always_comb scan_data = sc_data[scan_sel_q];

    // R9: ready drops right after an acceptance.
    assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !host_ready);
    // R9: ready returns after the single store cycle.
    assert_ready_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WR_STORE) |=> host_ready);
    // R2 and R3: a store goes to the store hidden when the write was accepted.
    assert_hidden_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_en) |-> (wr_en[0] == $past(disp_copy)));
    // R5: a zero word in transparency mode produces no store.
    assert_zero_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == WR_STORE) && trans_q && (data_q == '0)) |-> !(|wr_en));
    // R8: a disabled low lane keeps the old byte in the stored word.
    assert_lane_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|wr_en) && !be_q[0]) |-> (merged[LANE_W-1:0] == old_word[LANE_W-1:0]));
    // At most one store is written per cycle.
    assert_one_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));
endmodule

// File: tb/fb_host_writer_bench.sv
module fb_host_writer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int LAST = (1 << AW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ctrl_word = 16'h0000;
    logic        host_valid = 1'b0;
    logic        host_ready;
    logic [AW-1:0] host_addr = '0;
    logic [1:0]  host_be = 2'b00;
    logic [15:0] host_wdata = 16'h0000;
    logic        scan_sel = 1'b0;
    logic [AW-1:0] scan_addr = '0;
    logic [15:0] scan_data;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench model state
    logic [15:0] model [2][1 << AW];
    bit m_disp = 1'b0;
    bit m_trans = 1'b0;

    // Scoreboard queues
    logic [15:0] q_exp [$];
    string       q_req [$];
    bit rd_issue = 1'b0;
    bit armed = 1'b0;

    fb_host_writer #(.ADDR_W(AW)) u_fb_host_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_word  (ctrl_word),
        .host_valid (host_valid),
        .host_ready (host_ready),
        .host_addr  (host_addr),
        .host_be    (host_be),
        .host_wdata (host_wdata),
        .scan_sel   (scan_sel),
        .scan_addr  (scan_addr),
        .scan_data  (scan_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops one expected item per issued read, two edges later.
    always @(posedge clk) begin
        #2;
        if (armed) begin
            chk(q_req.pop_front(), scan_data, q_exp.pop_front());
        end
        armed = rd_issue;
        rd_issue = 1'b0;
    end

    // Model update for one accepted write.
    task automatic model_write(bit bank, int a, logic [15:0] d, logic [1:0] be, bit tr);
        logic [15:0] w;
        w = model[bank][a];
        if (tr && d == 16'h0000) return;
        for (int l = 0; l < 2; l++) begin
            if (be[l] && !(tr && d[l*8 +: 8] == 8'h00))
                w[l*8 +: 8] = d[l*8 +: 8];
        end
        model[bank][a] = w;
    endtask

    task automatic set_ctrl(bit disp, bit tr);
        ctrl_word = 16'h0000;
        ctrl_word[5] = disp;
        ctrl_word[6] = tr;
        m_disp = disp;
        m_trans = tr;
        repeat (2) @(posedge clk);
        #1;
    endtask

    // Driver: one host write, with the ready-drop check.
    task automatic wr(int a, logic [15:0] d, logic [1:0] be);
        @(posedge clk);
        #1;
        host_valid = 1'b1;
        host_addr = AW'(a);
        host_wdata = d;
        host_be = be;
        while (!host_ready) begin
            @(posedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        host_valid = 1'b0;
        model_write(!m_disp, a, d, be, m_trans);
        chk("R9 ready low after accept", {15'd0, host_ready}, 16'd0);
    endtask

    // Driver: one display-port read; expected value goes to the scoreboard.
    task automatic rd(bit bank, int a, string req);
        @(posedge clk);
        #1;
        scan_sel = bank;
        scan_addr = AW'(a);
        q_exp.push_back(model[bank][a]);
        q_req.push_back(req);
        rd_issue = 1'b1;
        repeat (2) @(posedge clk);
        #1;
    endtask

    initial begin
        // R1: request held through reset with bit 5 already set
        ctrl_word = 16'h0020;
        host_valid = 1'b1;
        host_addr = AW'(5);
        host_wdata = 16'hA1B2;
        host_be = 2'b11;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 ready low in reset", {15'd0, host_ready}, 16'd0);
        rst_n = 1'b1;
        #1;
        chk("R1 ready high after reset", {15'd0, host_ready}, 16'd1);
        @(posedge clk);
        #1;
        host_valid = 1'b0;
        chk("R9 ready low after first accept", {15'd0, host_ready}, 16'd0);
        model[1][5] = 16'hA1B2;
        @(posedge clk);
        #1;
        chk("R9 ready back high", {15'd0, host_ready}, 16'd1);
        rd(1'b1, 5, "R1 first write in store 1");

        // R2: bit 5 set, writes go to store 0
        set_ctrl(1'b1, 1'b0);
        for (int i = 0; i < 8; i++) wr(i, 16'h1000 + 16'(i * 16'h0111), 2'b11);
        wr(LAST, 16'hBEEF, 2'b11);
        for (int i = 0; i < 8; i++) rd(1'b0, i, "R2 store 0 written");
        rd(1'b1, 5, "R2 store 1 untouched");
        rd(1'b0, LAST, "R10 last address");

        // R3: bit 5 clear, writes go to store 1
        set_ctrl(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) wr(i, 16'h2000 + 16'(i * 16'h0203), 2'b11);
        for (int i = 0; i < 8; i++) rd(1'b1, i, "R3 store 1 written");
        for (int i = 0; i < 8; i++) rd(1'b0, i, "R3 store 0 untouched");

        // R4: plain byte-enable masking
        wr(1, 16'hC3C4, 2'b01);
        rd(1'b1, 1, "R4 low lane only");
        wr(2, 16'hD5D6, 2'b10);
        rd(1'b1, 2, "R4 high lane only");
        wr(3, 16'hE7E8, 2'b00);
        rd(1'b1, 3, "R4 no lane");
        wr(4, 16'h0000, 2'b11);
        rd(1'b1, 4, "R4 zero stored without transparency");

        // R5..R8: transparency
        set_ctrl(1'b0, 1'b1);
        wr(5, 16'h0000, 2'b11);
        rd(1'b1, 5, "R5 zero word skipped");
        wr(6, 16'h7700, 2'b11);
        rd(1'b1, 6, "R6 low byte kept");
        wr(7, 16'h0088, 2'b11);
        rd(1'b1, 7, "R7 high byte kept");
        wr(1, 16'h3300, 2'b01);
        rd(1'b1, 1, "R8 disabled nonzero high lane");
        wr(2, 16'h0044, 2'b10);
        rd(1'b1, 2, "R8 disabled nonzero low lane");
        wr(3, 16'h5566, 2'b01);
        rd(1'b1, 3, "R8 enabled lane after merge");
        wr(0, 16'h9A9B, 2'b11);
        rd(1'b1, 0, "R6 full nonzero word stored");

        // Transparency into store 0, boundary address
        set_ctrl(1'b1, 1'b1);
        wr(LAST, 16'h00F1, 2'b11);
        rd(1'b0, LAST, "R7 last address high kept");
        rd(1'b1, 7, "R2 store 1 untouched in transparency");

        // R9: back-to-back writes
        set_ctrl(1'b1, 1'b0);
        for (int i = 10; i < 16; i++) wr(i, 16'(i * 16'h1357), 2'b11);
        for (int i = 10; i < 16; i++) rd(1'b0, i, "R9 back-to-back writes");

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule